// File: doc/BRIEF.md
# Receive Bit Clock Generator

This block produces the receive bit clock of a serial audio port from a chain of two programmable stages. The first stage forms a high-rate receive clock. It either divides an internal auxiliary clock by a ratio from 1 to 4096 or takes a clock from an external pin. The result can be inverted. The second stage turns that high-rate clock into a bit clock. It either divides it by 1 to 32 or takes a bit clock from a second external pin, and the receive polarity can be inverted independently of the transmit side. A mode input lets the receiver follow the transmit bit clock instead of its own generated clock.

All clock-like inputs (auxiliary clock, both pins, transmit bit clock) are level signals sampled in the `clk` domain, and the dividers count their rising edges. Each divider stage registers its output, so a divided or bypassed clock appears one `clk` cycle after the input edge that caused it. Each pin gets a drive value and an output enable. An enable is raised only when the matching stage generates the clock itself.

Top module: `rx_clkgen`

## Requirements
- R1: The high-rate divider takes a 12-bit field N and gives one output period per N+1 rising edges of the auxiliary clock. With N = 0 the output is the auxiliary level delayed by one `clk` cycle.
- R2: The bit clock divider takes a 5-bit field M and gives one output period per M+1 rising edges of the high-rate clock. With M = 0 the output is the high-rate level delayed by one `clk` cycle.
- R3: For a divide ratio R of 2 or more, the output rises one `clk` cycle after the input rising edge that starts a period. It stays high for floor(R/2) input periods and low for the rest, so even ratios give 50% duty and odd ratios a high phase one input period shorter than the low phase.
- R4: `cfg_hf_int` = 1 selects the divided auxiliary clock as the high-rate source. 0 selects `hf_pin_i`.
- R5: `cfg_hf_inv` = 1 inverts the selected high-rate clock both where it feeds the bit divider and on `hf_pin_o`. `hf_pin_oe` equals `cfg_hf_int`.
- R6: `cfg_bclk_int` = 1 selects the bit divider output and 0 selects `bclk_pin_i`. `bclk_pin_oe` is 1 only when `cfg_bclk_int` = 1 and `cfg_async` = 1. `bclk_pin_o` carries the generated bit clock after the receive polarity.
- R7: `cfg_rx_inv` = 1 inverts `rx_bclk_o` whichever source is in use.
- R8: With `cfg_async` = 0, `rx_bclk_o` follows `tx_bclk_i` (after the receive polarity) and the generated clock has no effect on it.
- R9: A new divider field is taken only when the running count reaches its terminal value, so the period in progress completes with the old ratio.
- R10: While `rst_n` is low, both divider outputs and counters are cleared and the divided clocks are low. After `rst_n` rises, the dividers start on the third rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| aux_clk_i | input | 1 | Auxiliary clock level to divide |
| hf_pin_i | input | 1 | External high-rate clock from pin |
| bclk_pin_i | input | 1 | External bit clock from pin |
| tx_bclk_i | input | 1 | Transmit bit clock |
| cfg_hf_div | input | 12 | High-rate divide field (ratio = value + 1) |
| cfg_hf_int | input | 1 | High-rate source: 1 internal, 0 pin |
| cfg_hf_inv | input | 1 | High-rate polarity invert |
| cfg_bclk_div | input | 5 | Bit clock divide field (ratio = value + 1) |
| cfg_bclk_int | input | 1 | Bit clock source: 1 internal, 0 pin |
| cfg_rx_inv | input | 1 | Receive clock polarity invert |
| cfg_async | input | 1 | 1 uses own receive clock, 0 follows transmit clock |
| rx_bclk_o | output | 1 | Selected receive bit clock |
| hf_pin_o | output | 1 | Drive value for the high-rate pin |
| hf_pin_oe | output | 1 | Output enable for the high-rate pin |
| bclk_pin_o | output | 1 | Drive value for the bit clock pin |
| bclk_pin_oe | output | 1 | Output enable for the bit clock pin |

## Verification
The chain is exercised with a fast auxiliary clock (period of two samples) and a slow one (period of six). Stage ratios are even, odd, unity and both maxima. The measured high and low times of `rx_bclk_o` separate a wrong ratio from a wrong duty split on odd ratios. Runs with the external pins and the transmit clock as sources, each at a period different from every internal setting, show which mux leg feeds the output. Inversion runs swap the high and low times of an odd ratio, which exposes a polarity applied at the wrong point. Ratio changes made in mid-period are compared cycle by cycle against a model, which shows whether the old period completes first.

// File: rtl/rx_clkgen_pkg.sv
package rx_clkgen_pkg;
  localparam int unsigned HF_DIV_W_DEF   = 12;
  localparam int unsigned BCLK_DIV_W_DEF = 5;
  localparam int unsigned RST_STAGES_DEF = 2;

  typedef enum logic {
    SRC_PIN      = 1'b0,
    SRC_INTERNAL = 1'b1
  } clk_src_e;
endpackage

// File: rtl/rx_clkgen_rst_sync.sv
module rx_clkgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_n;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rx_clkgen_div.sv
module rx_clkgen_div #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_lvl,
  input  logic [W-1:0] ratio_cfg,
  output logic         q_o
);
  logic         prev_q, prev_n;
  logic         q_q, q_n;
  logic [W-1:0] cnt_q, cnt_n;
  logic [W-1:0] act_q, act_n;
  logic         edge_en;
  logic         term;
  logic [W:0]   hi_len;

  always_comb begin
    edge_en = in_lvl & ~prev_q;
    term    = (cnt_q == act_q);
    prev_n  = in_lvl;
    cnt_n   = cnt_q;
    act_n   = act_q;
    hi_len  = '0;
    q_n     = (act_q == '0) ? in_lvl : q_q;
    if (edge_en) begin
      if (term) begin
        cnt_n = '0;
        act_n = ratio_cfg;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
      hi_len = ({1'b0, act_n} + {{W{1'b0}}, 1'b1}) >> 1;
      q_n    = (act_n == '0) ? in_lvl : ({1'b0, cnt_n} < hi_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      q_q    <= 1'b0;
      cnt_q  <= '0;
      act_q  <= '0;
    end else begin
      prev_q <= prev_n;
      q_q    <= q_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/rx_clkgen_sel.sv
module rx_clkgen_sel (
  input  logic int_clk,
  input  logic ext_clk,
  input  logic use_int,
  input  logic invert,
  output logic sel_clk
);
  always_comb begin
    sel_clk = (use_int ? int_clk : ext_clk) ^ invert;
  end
endmodule

// File: rtl/rx_clkgen.sv
module rx_clkgen
  import rx_clkgen_pkg::*;
#(
  parameter int unsigned HF_DIV_W   = HF_DIV_W_DEF,
  parameter int unsigned BCLK_DIV_W = BCLK_DIV_W_DEF,
  parameter int unsigned RST_STAGES = RST_STAGES_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  aux_clk_i,
  input  logic                  hf_pin_i,
  input  logic                  bclk_pin_i,
  input  logic                  tx_bclk_i,
  input  logic [HF_DIV_W-1:0]   cfg_hf_div,
  input  logic                  cfg_hf_int,
  input  logic                  cfg_hf_inv,
  input  logic [BCLK_DIV_W-1:0] cfg_bclk_div,
  input  logic                  cfg_bclk_int,
  input  logic                  cfg_rx_inv,
  input  logic                  cfg_async,
  output logic                  rx_bclk_o,
  output logic                  hf_pin_o,
  output logic                  hf_pin_oe,
  output logic                  bclk_pin_o,
  output logic                  bclk_pin_oe
);
  logic rst_sync_n;
  logic hf_div_q;
  logic hf_clk;
  logic bclk_div_q;
  logic gen_bclk;
  logic rx_src;
  logic gen_bclk_pol;

  rx_clkgen_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rx_clkgen_div #(.W(HF_DIV_W)) u_hf_div (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_lvl    (aux_clk_i),
    .ratio_cfg (cfg_hf_div),
    .q_o       (hf_div_q)
  );

  rx_clkgen_sel u_hf_sel (
    .int_clk (hf_div_q),
    .ext_clk (hf_pin_i),
    .use_int (cfg_hf_int == SRC_INTERNAL),
    .invert  (cfg_hf_inv),
    .sel_clk (hf_clk)
  );

  rx_clkgen_div #(.W(BCLK_DIV_W)) u_bclk_div (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_lvl    (hf_clk),
    .ratio_cfg (cfg_bclk_div),
    .q_o       (bclk_div_q)
  );

  rx_clkgen_sel u_bclk_sel (
    .int_clk (bclk_div_q),
    .ext_clk (bclk_pin_i),
    .use_int (cfg_bclk_int == SRC_INTERNAL),
    .invert  (1'b0),
    .sel_clk (gen_bclk)
  );

  rx_clkgen_sel u_rx_sel (
    .int_clk (gen_bclk),
    .ext_clk (tx_bclk_i),
    .use_int (cfg_async),
    .invert  (cfg_rx_inv),
    .sel_clk (rx_src)
  );

  always_comb begin
    gen_bclk_pol = gen_bclk ^ cfg_rx_inv;
  end

  assign rx_bclk_o   = rx_src;
  assign hf_pin_o    = hf_clk;
  assign hf_pin_oe   = cfg_hf_int;
  assign bclk_pin_o  = gen_bclk_pol;
  assign bclk_pin_oe = cfg_bclk_int & cfg_async;
endmodule

// File: rtl/rx_clkgen_chk.sv
module rx_clkgen_chk #(
  parameter int unsigned HF_W = 12,
  parameter int unsigned BC_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [HF_W-1:0] hf_cnt,
  input logic [HF_W-1:0] hf_act,
  input logic            hf_q,
  input logic [BC_W-1:0] bc_cnt,
  input logic [BC_W-1:0] bc_act,
  input logic            bc_q,
  input logic            cfg_hf_int,
  input logic            cfg_hf_inv,
  input logic            cfg_rx_inv,
  input logic            cfg_async,
  input logic            tx_bclk_i,
  input logic            hf_pin_o,
  input logic            rx_bclk_o
);
  assert_reset_low_R10: assert property (@(posedge clk)
    !rst_n |-> (!hf_q && !bc_q && hf_cnt == '0 && bc_cnt == '0));

  assert_hf_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hf_cnt <= hf_act);

  assert_bclk_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bc_cnt <= bc_act);

  assert_hf_ratio_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hf_act) |-> hf_cnt == '0);

  assert_bclk_ratio_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bc_act) |-> bc_cnt == '0);

  assert_hf_pin_follows_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hf_int && !cfg_hf_inv) |-> hf_pin_o == hf_q);

  assert_sync_mode_tracks_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_async && $past(!cfg_async) && $stable(tx_bclk_i) && $stable(cfg_rx_inv))
      |-> $stable(rx_bclk_o));
endmodule

bind rx_clkgen rx_clkgen_chk #(.HF_W(HF_DIV_W), .BC_W(BCLK_DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hf_cnt     (u_hf_div.cnt_q),
  .hf_act     (u_hf_div.act_q),
  .hf_q       (u_hf_div.q_q),
  .bc_cnt     (u_bclk_div.cnt_q),
  .bc_act     (u_bclk_div.act_q),
  .bc_q       (u_bclk_div.q_q),
  .cfg_hf_int (cfg_hf_int),
  .cfg_hf_inv (cfg_hf_inv),
  .cfg_rx_inv (cfg_rx_inv),
  .cfg_async  (cfg_async),
  .tx_bclk_i  (tx_bclk_i),
  .hf_pin_o   (hf_pin_o),
  .rx_bclk_o  (rx_bclk_o)
);

// File: tb/rx_clkgen_bench.sv
`timescale 1ns/1ps
module rx_clkgen_bench;
  logic        clk;
  logic        rst_n;
  logic        aux_clk_i, hf_pin_i, bclk_pin_i, tx_bclk_i;
  logic [11:0] cfg_hf_div;
  logic        cfg_hf_int, cfg_hf_inv;
  logic [4:0]  cfg_bclk_div;
  logic        cfg_bclk_int, cfg_rx_inv, cfg_async;
  logic        rx_bclk_o, hf_pin_o, hf_pin_oe, bclk_pin_o, bclk_pin_oe;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R10";
  bit done = 0;

  int aux_half = 1, hfp_half = 2, bp_half = 3, tx_half = 5;
  int aux_c = 0, hfp_c = 0, bp_c = 0, tx_c = 0;

  // reference model state
  int m_rs1, m_rs2;
  int h_prev, h_cnt, h_act, h_q;
  int b_prev, b_cnt, b_act, b_q;

  rx_clkgen u_rx_clkgen (
    .clk(clk), .rst_n(rst_n), .aux_clk_i(aux_clk_i), .hf_pin_i(hf_pin_i),
    .bclk_pin_i(bclk_pin_i), .tx_bclk_i(tx_bclk_i), .cfg_hf_div(cfg_hf_div),
    .cfg_hf_int(cfg_hf_int), .cfg_hf_inv(cfg_hf_inv), .cfg_bclk_div(cfg_bclk_div),
    .cfg_bclk_int(cfg_bclk_int), .cfg_rx_inv(cfg_rx_inv), .cfg_async(cfg_async),
    .rx_bclk_o(rx_bclk_o), .hf_pin_o(hf_pin_o), .hf_pin_oe(hf_pin_oe),
    .bclk_pin_o(bclk_pin_o), .bclk_pin_oe(bclk_pin_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic div_step(input int in, input int cfg,
                          inout int prev, inout int cnt, inout int act, inout int q);
    if (in == 1 && prev == 0) begin
      if (cnt == act) begin cnt = 0; act = cfg; end
      else cnt = cnt + 1;
      q = (act == 0) ? in : ((cnt < (act + 1) / 2) ? 1 : 0);
    end else if (act == 0) begin
      q = in;
    end
    prev = in;
  endtask

  task automatic model_clear();
    m_rs1 = 0; m_rs2 = 0;
    h_prev = 0; h_cnt = 0; h_act = 0; h_q = 0;
    b_prev = 0; b_cnt = 0; b_act = 0; b_q = 0;
  endtask

  function automatic int m_hf();
    return ((cfg_hf_int ? h_q : int'(hf_pin_i)) ^ int'(cfg_hf_inv));
  endfunction
  function automatic int m_gen();
    return cfg_bclk_int ? b_q : int'(bclk_pin_i);
  endfunction

  always @(negedge rst_n) model_clear();

  always @(posedge clk) begin
    int run;
    int hfc;
    run = (m_rs2 == 1 && rst_n) ? 1 : 0;
    hfc = m_hf();
    if (!rst_n) begin
      model_clear();
    end else begin
      m_rs2 = m_rs1;
      m_rs1 = 1;
      if (run == 1) begin
        div_step(hfc, int'(cfg_bclk_div), b_prev, b_cnt, b_act, b_q);
        div_step(int'(aux_clk_i), int'(cfg_hf_div), h_prev, h_cnt, h_act, h_q);
      end
    end
  end

  // stimulus clocks, changed away from the active edge
  always @(negedge clk) begin
    aux_c++; if (aux_c >= aux_half) begin aux_c = 0; aux_clk_i = ~aux_clk_i; end
    hfp_c++; if (hfp_c >= hfp_half) begin hfp_c = 0; hf_pin_i = ~hf_pin_i; end
    bp_c++;  if (bp_c >= bp_half)   begin bp_c = 0;  bclk_pin_i = ~bclk_pin_i; end
    tx_c++;  if (tx_c >= tx_half)   begin tx_c = 0;  tx_bclk_i = ~tx_bclk_i; end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int gen;
      gen = m_gen();
      check(cur_tag, "rx_bclk_o", int'(rx_bclk_o),
            ((cfg_async ? gen : int'(tx_bclk_i)) ^ int'(cfg_rx_inv)));
      check(cur_tag, "hf_pin_o", int'(hf_pin_o), m_hf());
      check("R5", "hf_pin_oe", int'(hf_pin_oe), int'(cfg_hf_int));
      check(cur_tag, "bclk_pin_o", int'(bclk_pin_o), gen ^ int'(cfg_rx_inv));
      check("R6", "bclk_pin_oe", int'(bclk_pin_oe), int'(cfg_bclk_int & cfg_async));
    end
  end

  task automatic wait_level(input logic lvl);
    do begin @(negedge clk); #2; end while (rx_bclk_o !== lvl);
  endtask

  task automatic measure(input string tag, input int exp_per, input int exp_hi);
    int hi, per;
    wait_level(1'b0); wait_level(1'b1);
    wait_level(1'b0); wait_level(1'b1);
    hi = 0; per = 0;
    do begin @(negedge clk); #2; per++; if (rx_bclk_o !== 1'b1) break; hi++; end while (1);
    do begin @(negedge clk); #2; per++; end while (rx_bclk_o !== 1'b1);
    check(tag, "high time", hi + 1, exp_hi);
    check(tag, "period", per, exp_per);
  endtask

  task automatic setup(input int hfd, input bit hfi, input bit hfv,
                       input int bd, input bit bi, input bit rv, input bit as);
    @(negedge clk);
    cfg_hf_div = 12'(hfd); cfg_hf_int = hfi; cfg_hf_inv = hfv;
    cfg_bclk_div = 5'(bd); cfg_bclk_int = bi; cfg_rx_inv = rv; cfg_async = as;
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    rst_n = 1'b0;
    aux_clk_i = 0; hf_pin_i = 0; bclk_pin_i = 0; tx_bclk_i = 0;
    cfg_hf_div = 12'd2; cfg_hf_int = 1; cfg_hf_inv = 0;
    cfg_bclk_div = 5'd1; cfg_bclk_int = 1; cfg_rx_inv = 0; cfg_async = 1;
    repeat (4) @(negedge clk);
    #2;
    check("R10", "rx_bclk_o in reset", int'(rx_bclk_o), 0);
    check("R10", "hf_pin_o in reset", int'(hf_pin_o), 0);
    rst_n = 1'b1;
    // R10: dividers still held for two edges after release
    @(negedge clk); #2; check("R10", "held after release", int'(hf_pin_o), 0);

    cur_tag = "R3"; measure("R3", 12, 6);          // /3 then /2, fast aux
    cur_tag = "R1"; setup(0, 1, 0, 4, 1, 0, 1);
    measure("R3", 10, 4);                          // odd ratio 5 on bit stage
    cur_tag = "R7"; setup(0, 1, 0, 4, 1, 1, 1);
    measure("R7", 10, 6);
    cur_tag = "R9"; setup(0, 1, 0, 1, 1, 0, 1);    // ratio change mid-run
    repeat (40) @(negedge clk);
    setup(5, 1, 0, 1, 1, 0, 1);
    repeat (40) @(negedge clk);
    measure("R9", 24, 12);
    cur_tag = "R4"; setup(0, 0, 0, 2, 1, 0, 1);    // external high-rate pin
    measure("R4", 12, 4);
    cur_tag = "R5"; setup(0, 0, 1, 2, 1, 0, 1);
    measure("R5", 12, 4);
    cur_tag = "R6"; setup(2, 1, 0, 1, 0, 0, 1);    // external bit pin
    measure("R6", 6, 3);
    cur_tag = "R8"; setup(2, 1, 0, 1, 1, 0, 0);    // follow transmit clock
    measure("R8", 10, 5);
    setup(2, 1, 0, 1, 1, 1, 0);
    measure("R8", 10, 5);
    cur_tag = "R1"; aux_half = 3; setup(3, 1, 0, 0, 1, 0, 1);
    measure("R1", 24, 12);
    aux_half = 1; setup(4095, 1, 0, 0, 1, 0, 1);
    measure("R1", 8192, 4096);
    cur_tag = "R2"; setup(0, 1, 0, 31, 1, 0, 1);
    measure("R2", 64, 32);

    cur_tag = "R10";
    @(negedge clk); rst_n = 1'b0;
    #2;
    check("R10", "hf_pin_o mid reset", int'(hf_pin_o), 0);
    check("R10", "rx_bclk_o mid reset", int'(rx_bclk_o), 0);
    @(negedge clk); rst_n = 1'b1;
    measure("R2", 64, 32);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule